// File: doc/BRIEF.md
# Crossing Rate Alarm Detector

This block watches a one-bit detector flag in the one-eighth-sample-rate clock domain and measures the share of cycles in which it is high. Each observation window lasts a power-of-two number of cycles. At the close of a window the count is scaled to a signed 2.14 fraction of the window, compared against two programmable thresholds, and turned into a two-bit alarm. The alarm is then held unchanged until the next window closes.

Two output formats exist. In the normal format each alarm line reports its own threshold. In the two-bit format both lines together form one level code, with threshold 0 as the lower bound and threshold 1 as the upper bound. The counted flag is picked from one of two sources by a select input.

A five-state sequencer times the windows. `ST_LOAD` is entered only from reset and lasts one cycle. It then goes to `ST_OPEN`, or to `ST_SOLO` when the window length is one cycle. `ST_OPEN` is the first cycle of a multi-cycle window. From there it goes to `ST_CLOSE` for a two-cycle window, or to `ST_RUN`. `ST_RUN` holds for the middle cycles and goes to `ST_CLOSE` on the second-to-last position. `ST_CLOSE`, the last cycle, and `ST_SOLO`, a whole one-cycle window, both update the alarm. Both then start the next window at once, going to `ST_OPEN` or `ST_SOLO` with a freshly captured length.

Top module: `crossing_rate_alarm`

## Requirements
- R1: While reset is applied, and after its release until the first window has closed, `alarm` is 00.
- R2: A window lasts 2^`win_log2` cycles, for `win_log2` from 0 to 15. Windows follow each other with no gap. The first window starts on the second clock edge after reset is released. `win_log2` is captured only at a window boundary.
- R3: At window close the flag count is scaled to a 2.14 fraction, count × 2^(14 − N), where N is the captured `win_log2`. For N = 15 the count is halved instead. A flag high in every cycle gives 0x4000, and high in one cycle of eight gives 0x0800.
- R4: `thr0` and `thr1` are signed 2.14 values. A threshold is met when the fraction is at or above it. A negative threshold is therefore always met.
- R5: With `two_bit_en` = 0, `alarm[0]` is set when `thr0` is met and `alarm[1]` when `thr1` is met.
- R6: With `two_bit_en` = 1, `alarm` is 11 when `thr1` is met. Otherwise it is 01 when `thr0` is met, and 00 when neither is met. The code 10 never appears in this format.
- R7: `alarm` changes only on the clock edge that ends a window, and holds its value through the whole following window.
- R8: With `src_sel` = 0, `flag_blk` is counted and `flag_alt` has no effect. With `src_sel` = 1, `flag_alt` is counted and `flag_blk` has no effect.
- R9: The flag counter restarts at the first cycle of every window and saturates rather than wrapping. A window of 32768 cycles with the flag always high still yields the full-scale fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | One-eighth-sample-rate clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| flag_blk | input | 1 | Block detector flag, counted when `src_sel` = 0 |
| flag_alt | input | 1 | Alternate flag source, counted when `src_sel` = 1 |
| src_sel | input | 1 | Chooses the counted flag source |
| win_log2 | input | 4 | Window length exponent N; window = 2^N cycles |
| thr0 | input | 16 | Threshold 0 (lower bound in two-bit format), signed 2.14 |
| thr1 | input | 16 | Threshold 1 (upper bound in two-bit format), signed 2.14 |
| two_bit_en | input | 1 | Selects the two-bit level-code format |
| alarm | output | 2 | Alarm lines, updated at window close and then held |

## Verification
The hardest state to reach from the ports is a window whose count is known exactly, because the window phase is fixed inside the block and cannot be seen. The stimulus solves this with a periodic flag pattern, k cycles high out of every P, where P is a power of two no longer than the window. Any aligned window then holds exactly k/P of high cycles, whatever its phase. Each configuration is held for the rest of the old window plus two new windows before the alarm is read. The hold property is shown by reversing the flag pattern on the very cycle the alarm changes. The bench then watches that the alarm stays put for the whole next window and flips on its final edge. The longest windows are run at full and half duty to cover the top of the counter range.

// File: rtl/xra_pkg.sv
package xra_pkg;

    // Window sequencer states
    typedef enum logic [2:0] {
        ST_LOAD  = 3'd0,   // one cycle after reset, no counting
        ST_OPEN  = 3'd1,   // first cycle of a multi-cycle window
        ST_RUN   = 3'd2,   // middle cycles
        ST_CLOSE = 3'd3,   // last cycle, alarm update
        ST_SOLO  = 3'd4    // whole one-cycle window
    } win_state_e;

    // Level code for the two-bit format
    function automatic logic [1:0] level_code(input logic hit_lo, input logic hit_hi);
        logic [1:0] code;
        if (hit_hi)
            code = 2'b11;
        else if (hit_lo)
            code = 2'b01;
        else
            code = 2'b00;
        return code;
    endfunction

endpackage

// File: rtl/xra_window_ctrl.sv
module xra_window_ctrl
    import xra_pkg::*;
#(
    parameter int WIN_W = 4,
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_log2,
    output logic             win_open,
    output logic             win_close,
    output logic             counting,
    output logic             load_phase,
    output logic [WIN_W-1:0] n_q
);

    win_state_e       state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [WIN_W-1:0] n_d;
    logic [POS_W-1:0] span;

    assign span = POS_W'(1) << n_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            pos_q   <= '0;
            n_q     <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            n_q     <= n_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        n_d     = n_q;
        unique case (state_q)
            ST_LOAD, ST_CLOSE, ST_SOLO: begin
                n_d     = win_log2;
                pos_d   = '0;
                state_d = (win_log2 == '0) ? ST_SOLO : ST_OPEN;
            end
            ST_OPEN: begin
                pos_d   = POS_W'(1);
                state_d = (n_q == WIN_W'(1)) ? ST_CLOSE : ST_RUN;
            end
            ST_RUN: begin
                pos_d   = pos_q + POS_W'(1);
                state_d = (pos_q == span - POS_W'(2)) ? ST_CLOSE : ST_RUN;
            end
            default: begin
                state_d = ST_LOAD;
            end
        endcase
    end

    // Outputs
    always_comb begin
        win_open   = 1'b0;
        win_close  = 1'b0;
        counting   = 1'b1;
        load_phase = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                counting   = 1'b0;
                load_phase = 1'b1;
            end
            ST_OPEN:  win_open  = 1'b1;
            ST_RUN:   ;
            ST_CLOSE: win_close = 1'b1;
            ST_SOLO: begin
                win_open  = 1'b1;
                win_close = 1'b1;
            end
            default: counting = 1'b0;
        endcase
    end

    // R2: the middle position never reaches the last slot
    a_r2_run_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (pos_q >= POS_W'(1) && pos_q <= span - POS_W'(2)));

    // R2: windows follow one another without a gap
    a_r2_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        win_close |=> win_open);

    // R2: the length is only taken at a boundary
    a_r2_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !win_close) |=> $stable(n_q));

endmodule

// File: rtl/xra_hit_counter.sv
module xra_hit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             counting,
    input  logic             win_open,
    input  logic             flag,
    output logic [CNT_W-1:0] tally
);

    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;

    always_comb begin
        base  = win_open ? '0 : acc_q;
        sum   = {1'b0, base} + (CNT_W+1)'(flag);
        tally = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (counting)
            acc_q <= tally;
    end

    // R9: within a window the count never falls back
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !win_open) |=> (acc_q >= $past(acc_q)));

    // R9: the first cycle of a window starts afresh
    a_r9_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && win_open) |=> (acc_q <= CNT_W'(1)));

endmodule

// File: rtl/xra_scaler.sv
module xra_scaler #(
    parameter int WIN_W     = 4,
    parameter int CNT_W     = 16,
    parameter int FRAC_W    = 16,
    parameter int FRAC_BITS = 14
) (
    input  logic [CNT_W-1:0]  tally,
    input  logic [WIN_W-1:0]  n_q,
    output logic [FRAC_W-1:0] frac
);

    localparam int WIDE_W = CNT_W + FRAC_BITS;
    localparam logic [WIDE_W-1:0] MAXPOS = WIDE_W'((64'd1 << (FRAC_W - 1)) - 64'd1);

    logic [WIDE_W-1:0] ext;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        ext = WIDE_W'(tally);
        if (int'(n_q) <= FRAC_BITS)
            wide = ext << (FRAC_BITS - int'(n_q));
        else
            wide = ext >> (int'(n_q) - FRAC_BITS);
        if (wide > MAXPOS)
            wide = MAXPOS;
        frac = wide[FRAC_W-1:0];
    end

endmodule

// File: rtl/xra_alarm_ctrl.sv
module xra_alarm_ctrl
    import xra_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              update,
    input  logic              two_bit,
    input  logic [FRAC_W-1:0] frac,
    input  logic [FRAC_W-1:0] thr0,
    input  logic [FRAC_W-1:0] thr1,
    output logic [1:0]        alarm_q
);

    logic       hit0, hit1;
    logic [1:0] code_d;

    always_comb begin
        hit0 = $signed(frac) >= $signed(thr0);
        hit1 = $signed(frac) >= $signed(thr1);
        if (two_bit)
            code_d = level_code(hit0, hit1);
        else
            code_d = {hit1, hit0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_q <= 2'b00;
        else if (update)
            alarm_q <= code_d;
    end

    // R7: outside a window close the alarm does not move
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(alarm_q));

    // R6: the level code never takes the unused value
    a_r6_no_split_code: assert property (@(posedge clk) disable iff (!rst_n)
        (update && two_bit) |=> (alarm_q != 2'b10));

    // R4: a negative threshold is always met at close
    a_r4_negative_met: assert property (@(posedge clk) disable iff (!rst_n)
        (update && !two_bit && thr0[FRAC_W-1]) |=> alarm_q[0]);

endmodule

// File: rtl/crossing_rate_alarm.sv
module crossing_rate_alarm #(
    parameter int WIN_W     = 4,
    parameter int FRAC_W    = 16,
    parameter int FRAC_BITS = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_blk,
    input  logic              flag_alt,
    input  logic              src_sel,
    input  logic [WIN_W-1:0]  win_log2,
    input  logic [FRAC_W-1:0] thr0,
    input  logic [FRAC_W-1:0] thr1,
    input  logic              two_bit_en,
    output logic [1:0]        alarm
);

    localparam int CNT_W = 2 ** WIN_W;
    localparam logic [FRAC_W-1:0] FULL_SCALE = FRAC_W'(64'd1 << FRAC_BITS);

    logic             win_open, win_close, counting, load_phase;
    logic [WIN_W-1:0] n_q;
    logic             flag_sel;
    logic [CNT_W-1:0] tally;
    logic [FRAC_W-1:0] frac;

    assign flag_sel = src_sel ? flag_alt : flag_blk;

    xra_window_ctrl #(
        .WIN_W (WIN_W),
        .POS_W (CNT_W)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_log2   (win_log2),
        .win_open   (win_open),
        .win_close  (win_close),
        .counting   (counting),
        .load_phase (load_phase),
        .n_q        (n_q)
    );

    xra_hit_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .counting (counting),
        .win_open (win_open),
        .flag     (flag_sel),
        .tally    (tally)
    );

    xra_scaler #(
        .WIN_W     (WIN_W),
        .CNT_W     (CNT_W),
        .FRAC_W    (FRAC_W),
        .FRAC_BITS (FRAC_BITS)
    ) u_scaler (
        .tally (tally),
        .n_q   (n_q),
        .frac  (frac)
    );

    xra_alarm_ctrl #(
        .FRAC_W (FRAC_W)
    ) u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .update  (win_close),
        .two_bit (two_bit_en),
        .frac    (frac),
        .thr0    (thr0),
        .thr1    (thr1),
        .alarm_q (alarm)
    );

    // R1: nothing is reported before the first window
    a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        load_phase |-> (alarm == 2'b00));

    // R3: the scaled fraction never exceeds full scale
    a_r3_frac_cap: assert property (@(posedge clk) disable iff (!rst_n)
        counting |-> (frac <= FULL_SCALE));

endmodule

// File: tb/crossing_rate_alarm_bench.sv
`timescale 1ns/1ps
module crossing_rate_alarm_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flag_blk = 1'b0;
    logic        flag_alt = 1'b0;
    logic        src_sel;
    logic [3:0]  win_log2;
    logic [15:0] thr0, thr1;
    logic        two_bit_en;
    logic [1:0]  alarm;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int pat_p  = 4;
    int pat_k  = 4;
    logic alt_v = 1'b0;

    always #2.5 clk = ~clk;

    crossing_rate_alarm u_crossing_rate_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_blk   (flag_blk),
        .flag_alt   (flag_alt),
        .src_sel    (src_sel),
        .win_log2   (win_log2),
        .thr0       (thr0),
        .thr1       (thr1),
        .two_bit_en (two_bit_en),
        .alarm      (alarm)
    );

    // Periodic flag pattern: pat_k high cycles out of every pat_p
    always @(negedge clk) begin
        cyc      <= cyc + 1;
        flag_blk <= ((cyc % pat_p) < pat_k);
        flag_alt <= alt_v;
    end

    // {req, n, two_bit, sel, thr0, thr1, log2 period, high count, alt level, expected}
    localparam int NV = 17;
    localparam logic [52:0] VEC [NV] = '{
        {4'd5, 4'd4, 1'b0, 1'b0, 16'h2000, 16'h3000, 3'd2, 5'd1, 1'b0, 2'b00}, // R5 25%
        {4'd4, 4'd4, 1'b0, 1'b0, 16'h2000, 16'h3000, 3'd2, 5'd2, 1'b0, 2'b01}, // R4 equal
        {4'd5, 4'd4, 1'b0, 1'b0, 16'h2000, 16'h3000, 3'd2, 5'd3, 1'b0, 2'b11}, // R5 75%
        {4'd3, 4'd4, 1'b0, 1'b0, 16'h2000, 16'h3000, 3'd2, 5'd4, 1'b0, 2'b11}, // R3 full
        {4'd5, 4'd4, 1'b0, 1'b0, 16'h2001, 16'h1FFF, 3'd2, 5'd2, 1'b0, 2'b10}, // R5 only thr1
        {4'd6, 4'd4, 1'b1, 1'b0, 16'h2001, 16'h1FFF, 3'd2, 5'd2, 1'b0, 2'b11}, // R6 upper wins
        {4'd6, 4'd4, 1'b1, 1'b0, 16'h1000, 16'h3000, 3'd2, 5'd2, 1'b0, 2'b01}, // R6 between
        {4'd6, 4'd4, 1'b1, 1'b0, 16'h1000, 16'h3000, 3'd2, 5'd0, 1'b0, 2'b00}, // R6 below
        {4'd2, 4'd0, 1'b0, 1'b0, 16'h4000, 16'h4001, 3'd0, 5'd1, 1'b0, 2'b01}, // R2 one-cycle window
        {4'd3, 4'd6, 1'b0, 1'b0, 16'h0800, 16'h0801, 3'd3, 5'd1, 1'b0, 2'b01}, // R3 12.5%
        {4'd3, 4'd6, 1'b0, 1'b0, 16'h0801, 16'h0800, 3'd3, 5'd1, 1'b0, 2'b10}, // R3 one LSB short
        {4'd4, 4'd3, 1'b0, 1'b0, 16'hC000, 16'h4001, 3'd1, 5'd0, 1'b0, 2'b01}, // R4 negative
        {4'd8, 4'd3, 1'b0, 1'b1, 16'h0001, 16'h0001, 3'd2, 5'd4, 1'b0, 2'b00}, // R8 blk ignored
        {4'd8, 4'd3, 1'b0, 1'b1, 16'h0001, 16'h0001, 3'd2, 5'd0, 1'b1, 2'b11}, // R8 alt counted
        {4'd3, 4'd5, 1'b0, 1'b0, 16'h0E00, 16'h0E01, 3'd5, 5'd7, 1'b0, 2'b01}, // R3 7/32
        {4'd6, 4'd5, 1'b1, 1'b0, 16'h0E01, 16'h4000, 3'd5, 5'd7, 1'b0, 2'b00}, // R6 just below
        {4'd6, 4'd2, 1'b1, 1'b0, 16'h0000, 16'h4000, 3'd2, 5'd4, 1'b0, 2'b11}  // R6 top
    };

    task automatic check2(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run incomplete actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [52:0] v;
        int          prev_n;
        logic [1:0]  held;
        int          moved;
        int          t;

        rst_n      = 1'b0;
        src_sel    = 1'b0;
        win_log2   = 4'd4;
        thr0       = 16'h0000;
        thr1       = 16'h0000;
        two_bit_en = 1'b0;
        pat_p      = 4;
        pat_k      = 4;
        step(4);
        check2("R1 during reset", alarm, 2'b00);
        rst_n = 1'b1;
        step(3);
        check2("R1 before first close", alarm, 2'b00);
        step(30);
        check2("R2 first window closed", alarm, 2'b11);
        prev_n = 4;

        for (int i = 0; i < NV; i++) begin
            v          = VEC[i];
            win_log2   = v[48:45];
            two_bit_en = v[44];
            src_sel    = v[43];
            thr0       = v[42:27];
            thr1       = v[26:11];
            pat_p      = 1 << v[10:8];
            pat_k      = int'(v[7:3]);
            alt_v      = v[2];
            step((1 << prev_n) + 2 * (1 << int'(v[48:45])) + 6);
            check2($sformatf("R%0d vector %0d", v[52:49], i), alarm, v[1:0]);
            prev_n = int'(v[48:45]);
        end

        // R7: hold through the following window
        win_log2   = 4'd4;
        two_bit_en = 1'b0;
        src_sel    = 1'b0;
        alt_v      = 1'b0;
        thr0       = 16'h2000;
        thr1       = 16'h3000;
        pat_p      = 4;
        pat_k      = 4;
        step((1 << prev_n) + 32 + 6);
        check2("R7 setup level", alarm, 2'b11);
        pat_k = 0;
        t = 0;
        while (alarm == 2'b11 && t < 40) begin
            step(1);
            t++;
        end
        check2("R7 drop at close", alarm, 2'b00);
        pat_k = 4;
        held  = alarm;
        moved = 0;
        for (int j = 0; j < 15; j++) begin
            step(1);
            if (alarm !== held) moved++;
        end
        check2("R7 held through window", (moved == 0) ? 2'b00 : 2'b01, 2'b00);
        step(1);
        check2("R7 update on window end", alarm, 2'b11);

        // R1: reset in mid run
        rst_n = 1'b0;
        step(1);
        check2("R1 reset mid run", alarm, 2'b00);
        rst_n = 1'b1;
        step(2);
        check2("R1 after second release", alarm, 2'b00);
        prev_n = 4;

        // R3 R9: long windows at the top of the counter range
        win_log2 = 4'd14;
        thr0     = 16'h4000;
        thr1     = 16'h4001;
        pat_p    = 1;
        pat_k    = 1;
        step((1 << prev_n) + 2 * (1 << 14) + 6);
        check2("R3 R9 window 2^14 full", alarm, 2'b01);
        prev_n   = 14;
        win_log2 = 4'd15;
        thr0     = 16'h2000;
        thr1     = 16'h2001;
        pat_p    = 2;
        pat_k    = 1;
        step((1 << prev_n) + 2 * (1 << 15) + 6);
        check2("R3 R9 window 2^15 half", alarm, 2'b01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule